// File: doc/BRIEF.md
# Power-Management I2C Register-Write Engine

This block is a small, dedicated I2C master that puts one register write onto a bus that serves an external power-management device. Software fills a packed command word with the target's 7-bit address, the register index inside that device and the byte to store. It then writes the same word again with a launch flag set. The engine runs the whole bus transaction by itself: a start condition, three bytes each followed by an acknowledge slot, and a stop condition. When the transaction ends, the engine drops the launch flag. Software learns that the write is complete by polling that flag.

A second register sets the two SCL phase lengths in system-clock cycles. Each phase has a fixed offset added in hardware. A third register holds a master code and a high-speed enable that is kept off. A fourth register holds a sticky error flag, which is set when the target does not acknowledge. Both bus lines are open-drain: an output-enable of 1 pulls the line low, and the line is released otherwise.

Top module: `pwr_i2c_writer`

## Requirements
- R1: Register select 0 is the command word: target address in bits 6:0, register index in bits 15:8, data byte in bits 23:16, launch flag in bit 24. Bit 7 and bits 31:25 read as 0. A write with bit 24 at 0 stores the fields and starts no transfer.
- R2: A write to select 0 with bit 24 at 1 while idle starts a transfer. Bus activity begins two cycles after the write edge. Bit 24 reads 1 from the write edge until the edge that ends the last bus phase, and reads 0 after that.
- R3: The bus sequence is: start; address byte with write bit 0; acknowledge slot; register index; acknowledge slot; data byte; acknowledge slot; stop. Bits go out MSB first. An output-enable of 1 pulls the line low. Both enables are 0 while idle.
- R4: Each SCL low phase lasts the low count plus 7 cycles. Each SCL high phase lasts the high count plus 5 cycles. The start hold, the stop high phase and the final bus-free phase each last the high count plus 5 cycles.
- R5: The SDA enable takes the value of a new phase on the second cycle of that phase. SDA therefore changes while SCL is high only for the start condition (pull) and the stop condition (release).
- R6: Register select 1 holds the SCL high count in bits 7:0 and the low count in bits 15:8. Bits 31:16 read as 0.
- R7: Register select 2 stores a 3-bit master code in bits 2:0. The high-speed enable in bit 3 always reads 0, and so do all higher bits.
- R8: A write to select 0 while bit 24 reads 1 is ignored. The fields and the flag stay unchanged, and no second transfer follows.
- R9: The acknowledge is sampled on the last cycle of each acknowledge high phase. If the line is high there (no acknowledge), the engine goes straight to stop, sends no further byte, clears bit 24 at the end, and sets status bit 0 of select 3.
- R10: Status bit 0 is cleared by writing 1 to it. Writing 0 has no effect. If an error is set in the same cycle as a clearing write, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 command, 1 clock, 2 mode, 3 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| sda_in | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
Two events can land on the same edge: the engine completing a transfer that was not acknowledged, which sets the sticky error, and software writing 1 to clear that error. The bench provokes this by watching its own cycle-accurate bus model and issuing the clearing write during the final bus-free cycle. It then judges the outcome by reading status bit 0, which must still be 1; a second clearing write, made later, must bring the bit to 0. A command write placed in the middle of a transfer is judged the same way: it must leave the readback unchanged and cause no extra bus activity.

// File: rtl/pwr_i2c_pkg.sv
`timescale 1ns/1ps
// Shared constants and types of the power-management I2C write engine.
// Assumes the fixed 32-bit register layout described in the brief.
package pwr_i2c_pkg;
    localparam int FIELD_W   = 8;
    localparam int ADDR_W    = 7;
    localparam int SEL_W     = 2;
    localparam int REG_W     = 32;
    localparam int GO_BIT    = 24;
    localparam int ACK_SLOT  = 8;

    localparam logic [SEL_W-1:0] SEL_CMD  = 2'd0;
    localparam logic [SEL_W-1:0] SEL_CLK  = 2'd1;
    localparam logic [SEL_W-1:0] SEL_MODE = 2'd2;
    localparam logic [SEL_W-1:0] SEL_STAT = 2'd3;

    typedef enum logic [2:0] {
        PH_IDLE, PH_START, PH_LOW, PH_HIGH, PH_STOP_LO, PH_STOP_HI, PH_FREE
    } phase_e;
endpackage

// File: rtl/pwr_i2c_timer.sv
`timescale 1ns/1ps
// Phase down-counter: loaded with (length-1) on entry to a phase, it flags
// expiry on the last cycle of that phase. Assumes load has priority.
module pwr_i2c_timer #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    // Count down toward zero, reload when a new phase begins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/pwr_i2c_regs.sv
`timescale 1ns/1ps
// Software-visible registers: command word with self-clearing launch flag,
// SCL phase counts, mode (master code only, high-speed forced off) and a
// sticky write-1-to-clear error. Assumes xfer_done is a one-cycle pulse.
module pwr_i2c_regs
    import pwr_i2c_pkg::*;
#(
    parameter logic [FIELD_W-1:0] RST_HI = 8'd35,
    parameter logic [FIELD_W-1:0] RST_LO = 8'd55
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_we,
    input  logic [SEL_W-1:0]   reg_sel,
    input  logic [REG_W-1:0]   reg_wdata,
    input  logic               xfer_done,
    input  logic               xfer_nack,
    output logic [REG_W-1:0]   reg_rdata,
    output logic [ADDR_W-1:0]  tgt_addr,
    output logic [FIELD_W-1:0] reg_addr,
    output logic [FIELD_W-1:0] wr_data,
    output logic               cmd_valid,
    output logic [FIELD_W-1:0] hi_cnt,
    output logic [FIELD_W-1:0] lo_cnt,
    output logic               err_flag
);
    logic [2:0] mcode_q;
    logic       cmd_wr;
    logic       unused_wbits;

    assign cmd_wr       = reg_we && (reg_sel == SEL_CMD) && !cmd_valid;
    assign unused_wbits = ^reg_wdata[REG_W-1:GO_BIT+1];

    // Command fields and launch flag; writes while busy are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_addr  <= '0;
            reg_addr  <= '0;
            wr_data   <= '0;
            cmd_valid <= 1'b0;
        end else if (cmd_wr) begin
            tgt_addr  <= reg_wdata[ADDR_W-1:0];
            reg_addr  <= reg_wdata[2*FIELD_W-1:FIELD_W];
            wr_data   <= reg_wdata[3*FIELD_W-1:2*FIELD_W];
            cmd_valid <= reg_wdata[GO_BIT];
        end else if (xfer_done) begin
            cmd_valid <= 1'b0;
        end
    end

    // SCL phase counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= RST_HI;
            lo_cnt <= RST_LO;
        end else if (reg_we && reg_sel == SEL_CLK) begin
            hi_cnt <= reg_wdata[FIELD_W-1:0];
            lo_cnt <= reg_wdata[2*FIELD_W-1:FIELD_W];
        end
    end

    // Master code storage; the high-speed enable is never stored.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mcode_q <= '0;
        else if (reg_we && reg_sel == SEL_MODE)
            mcode_q <= reg_wdata[2:0];
    end

    // Sticky error: setting at completion wins over a clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_flag <= 1'b0;
        else if (xfer_done && xfer_nack)
            err_flag <= 1'b1;
        else if (reg_we && reg_sel == SEL_STAT && reg_wdata[0])
            err_flag <= 1'b0;
    end

    // Read multiplexer over the four registers.
    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_CMD:  reg_rdata = {7'd0, cmd_valid, wr_data, reg_addr, 1'b0, tgt_addr};
            SEL_CLK:  reg_rdata = {16'd0, lo_cnt, hi_cnt};
            SEL_MODE: reg_rdata = {29'd0, mcode_q};
            default:  reg_rdata = {31'd0, err_flag};
        endcase
    end
endmodule

// File: rtl/pwr_i2c_seq.sv
`timescale 1ns/1ps
// Bus sequencer: start, three bytes with acknowledge slots, stop, bus-free.
// SDA enable is a registered copy of the phase target, so it moves on the
// second cycle of each phase. Assumes fields are stable while go is high.
module pwr_i2c_seq
    import pwr_i2c_pkg::*;
#(
    parameter int LO_ADD = 7,
    parameter int HI_ADD = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go,
    input  logic [ADDR_W-1:0]  tgt_addr,
    input  logic [FIELD_W-1:0] reg_addr,
    input  logic [FIELD_W-1:0] wr_data,
    input  logic [FIELD_W-1:0] hi_cnt,
    input  logic [FIELD_W-1:0] lo_cnt,
    input  logic               sda_in,
    output logic               scl_oe,
    output logic               sda_oe,
    output logic               done,
    output logic               nack,
    output phase_e             state
);
    localparam int PH_W = FIELD_W + 1;

    phase_e              nxt;
    logic [1:0]          byte_q;
    logic [3:0]          bit_q;
    logic                adv;
    logic                expired;
    logic                pull_tgt;
    logic                cur_bit;
    logic [FIELD_W-1:0]  cur_byte;
    logic [PH_W-1:0]     load_val;
    logic                last_byte;
    logic                in_ack;

    assign last_byte = (byte_q == 2'd2);
    assign in_ack    = (bit_q == 4'(ACK_SLOT));

    pwr_i2c_timer #(.W(PH_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (adv),
        .load_val (load_val),
        .expired  (expired)
    );

    // Select the byte on the wire and the bit within it, MSB first.
    always_comb begin
        case (byte_q)
            2'd0:    cur_byte = {tgt_addr, 1'b0};
            2'd1:    cur_byte = reg_addr;
            default: cur_byte = wr_data;
        endcase
        cur_bit = cur_byte[3'd7 - bit_q[2:0]];
    end

    // Next-phase decision at the end of each phase.
    always_comb begin
        nxt = state;
        adv = 1'b0;
        if (state == PH_IDLE) begin
            if (go) begin
                nxt = PH_START;
                adv = 1'b1;
            end
        end else if (expired) begin
            adv = 1'b1;
            case (state)
                PH_START:   nxt = PH_LOW;
                PH_LOW:     nxt = PH_HIGH;
                PH_HIGH:    nxt = (in_ack && (sda_in || last_byte)) ? PH_STOP_LO : PH_LOW;
                PH_STOP_LO: nxt = PH_STOP_HI;
                PH_STOP_HI: nxt = PH_FREE;
                default:    nxt = PH_IDLE;
            endcase
        end
    end

    // Phase length for the phase being entered, offsets included.
    always_comb begin
        if (nxt == PH_LOW || nxt == PH_STOP_LO)
            load_val = PH_W'(lo_cnt) + PH_W'(LO_ADD - 1);
        else
            load_val = PH_W'(hi_cnt) + PH_W'(HI_ADD - 1);
    end

    // SDA pull target of the present phase.
    always_comb begin
        case (state)
            PH_START, PH_STOP_LO, PH_STOP_HI: pull_tgt = 1'b1;
            PH_LOW, PH_HIGH:                  pull_tgt = !in_ack && !cur_bit;
            default:                          pull_tgt = 1'b0;
        endcase
    end

    // Phase, position and acknowledge bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= PH_IDLE;
            byte_q <= '0;
            bit_q  <= '0;
            nack   <= 1'b0;
            sda_oe <= 1'b0;
        end else begin
            state  <= nxt;
            sda_oe <= pull_tgt;
            if (state == PH_IDLE && go)
                nack <= 1'b0;
            if (adv && state == PH_START) begin
                byte_q <= '0;
                bit_q  <= '0;
            end else if (adv && state == PH_HIGH) begin
                if (in_ack) begin
                    if (sda_in)
                        nack <= 1'b1;
                    byte_q <= byte_q + 1'b1;
                    bit_q  <= '0;
                end else begin
                    bit_q <= bit_q + 1'b1;
                end
            end
        end
    end

    assign scl_oe = (state == PH_LOW) || (state == PH_STOP_LO);
    assign done   = (state == PH_FREE) && expired;
endmodule

// File: rtl/pwr_i2c_writer.sv
`timescale 1ns/1ps
// Top of the power-management I2C write engine: registers plus sequencer.
// Assumes an open-drain bus with external pull-ups and no clock stretching.
module pwr_i2c_writer
    import pwr_i2c_pkg::*;
#(
    parameter logic [FIELD_W-1:0] RST_HI = 8'd35,
    parameter logic [FIELD_W-1:0] RST_LO = 8'd55,
    parameter int                 LO_ADD = 7,
    parameter int                 HI_ADD = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [SEL_W-1:0] reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe
);
    logic [ADDR_W-1:0]  cmd_addr;
    logic [FIELD_W-1:0] cmd_reg;
    logic [FIELD_W-1:0] cmd_data;
    logic               cmd_valid;
    logic [FIELD_W-1:0] hi_cnt;
    logic [FIELD_W-1:0] lo_cnt;
    logic               err_flag;
    logic               seq_done;
    logic               seq_nack;
    phase_e             seq_state;

    pwr_i2c_regs #(.RST_HI(RST_HI), .RST_LO(RST_LO)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .xfer_done (seq_done),
        .xfer_nack (seq_nack),
        .reg_rdata (reg_rdata),
        .tgt_addr  (cmd_addr),
        .reg_addr  (cmd_reg),
        .wr_data   (cmd_data),
        .cmd_valid (cmd_valid),
        .hi_cnt    (hi_cnt),
        .lo_cnt    (lo_cnt),
        .err_flag  (err_flag)
    );

    pwr_i2c_seq #(.LO_ADD(LO_ADD), .HI_ADD(HI_ADD)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (cmd_valid),
        .tgt_addr (cmd_addr),
        .reg_addr (cmd_reg),
        .wr_data  (cmd_data),
        .hi_cnt   (hi_cnt),
        .lo_cnt   (lo_cnt),
        .sda_in   (sda_in),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe),
        .done     (seq_done),
        .nack     (seq_nack),
        .state    (seq_state)
    );
endmodule

// File: rtl/pwr_i2c_checker.sv
`timescale 1ns/1ps
// Property checker for the write engine, attached to the top by bind.
module pwr_i2c_checker
    import pwr_i2c_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             scl_oe,
    input logic             sda_oe,
    input logic             busy,
    input logic             done,
    input phase_e           st,
    input logic [22:0]      cmd_word,
    input logic             err,
    input logic             reg_we,
    input logic [SEL_W-1:0] reg_sel,
    input logic             wdata0
);
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe)); // R3

    AST_SDA_PULL_IN_START: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && !scl_oe && $past(!scl_oe)) |-> $past(st == PH_START)); // R5

    AST_SDA_FREE_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_oe) && !scl_oe && $past(!scl_oe)) |-> $past(st == PH_FREE)); // R5

    AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cmd_word)); // R8

    AST_FLAG_DROPS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done)); // R2

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !(reg_we && reg_sel == SEL_STAT && wdata0)) |=> err); // R10
endmodule

bind pwr_i2c_writer pwr_i2c_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .busy     (cmd_valid),
    .done     (seq_done),
    .st       (seq_state),
    .cmd_word ({cmd_addr, cmd_reg, cmd_data}),
    .err      (err_flag),
    .reg_we   (reg_we),
    .reg_sel  (reg_sel),
    .wdata0   (reg_wdata[0])
);

// File: tb/pwr_i2c_writer_test.sv
`timescale 1ns/1ps
// Bench: a per-cycle behavioural model of the bus (a queue of expected
// line states built from the requirements) compared on every clock.
module pwr_i2c_writer_test;
    localparam logic [7:0] T_RST_HI = 8'd35;
    localparam logic [7:0] T_RST_LO = 8'd55;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        scl_oe;
    logic        sda_oe;
    logic        sda_in;
    logic        ack_drv = 1'b0;

    int          checks = 0;
    int          errors = 0;
    int          lead = 0;
    logic        cur_busy = 1'b0;
    logic        prev_tgt = 1'b0;
    logic [2:0]  expq[$];
    bit          finished = 0;

    always #2.5 clk = ~clk;

    assign sda_in = ~(sda_oe | ack_drv);

    pwr_i2c_writer #(.RST_HI(T_RST_HI), .RST_LO(T_RST_LO)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sda_in    (sda_in),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic push_phase(input logic scl, input logic tgt, input logic ack, input int dur);
        for (int i = 0; i < dur; i++)
            expq.push_back({scl, (i == 0) ? prev_tgt : tgt, ack});
        prev_tgt = tgt;
    endtask

    // Expected bus for one write; nack_at = byte that is not acknowledged (3 = none).
    task automatic build(input logic [6:0] a, input logic [7:0] r, input logic [7:0] d,
                         input int hi, input int lo, input int nack_at);
        int hl = hi + 5;
        int ll = lo + 7;
        logic [7:0] b;
        prev_tgt = 1'b0;
        push_phase(1'b0, 1'b1, 1'b0, hl);
        for (int k = 0; k < 3; k++) begin
            b = (k == 0) ? {a, 1'b0} : (k == 1) ? r : d;
            for (int i = 7; i >= 0; i--) begin
                push_phase(1'b1, ~b[i], 1'b0, ll);
                push_phase(1'b0, ~b[i], 1'b0, hl);
            end
            push_phase(1'b1, 1'b0, k != nack_at, ll);
            push_phase(1'b0, 1'b0, k != nack_at, hl);
            if (k == nack_at) break;
        end
        push_phase(1'b1, 1'b1, 1'b0, ll);
        push_phase(1'b0, 1'b1, 1'b0, hl);
        push_phase(1'b0, 1'b0, 1'b0, hl);
    endtask

    // Per-cycle comparison, sampled well after each rising edge.
    always @(posedge clk) begin
        logic [2:0] e;
        #1.5;
        if (!rst_n) begin
            ack_drv  = 1'b0;
            cur_busy = 1'b0;
        end else if (lead > 0) begin
            lead--;
            cur_busy = 1'b1;
            ack_drv  = 1'b0;
            chk(!scl_oe && !sda_oe, "R2 bus quiet in launch cycle", {scl_oe, sda_oe}, 0);
        end else if (expq.size() > 0) begin
            e = expq.pop_front();
            cur_busy = 1'b1;
            ack_drv  = e[0];
            chk(scl_oe === e[2], "R4 scl_oe phase timing", 32'(scl_oe), 32'(e[2]));
            chk(sda_oe === e[1], "R5 sda_oe bit/second-cycle rule", 32'(sda_oe), 32'(e[1]));
        end else begin
            cur_busy = 1'b0;
            ack_drv  = 1'b0;
            chk(!scl_oe && !sda_oe, "R3 idle lines released", {scl_oe, sda_oe}, 0);
        end
    end

    task automatic wr(input logic [1:0] s, input logic [31:0] v);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = v;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] s, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_sel = s;
        #1;
        chk(reg_rdata === exp, tag, reg_rdata, exp);
    endtask

    task automatic launch(input logic [6:0] a, input logic [7:0] r, input logic [7:0] d,
                          input int hi, input int lo, input int nack_at);
        wr(2'd1, {16'd0, 8'(lo), 8'(hi)});
        wr(2'd0, {7'd0, 1'b0, d, r, 1'b0, a});
        @(negedge clk);
        build(a, r, d, hi, lo, nack_at);
        lead = 1;
        reg_we = 1'b1; reg_sel = 2'd0; reg_wdata = {7'd0, 1'b1, d, r, 1'b0, a};
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (lead > 0 || expq.size() > 0 || cur_busy);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        rd_chk(2'd0, 32'h0, "R1 reset command word");
        rd_chk(2'd1, {16'd0, T_RST_LO, T_RST_HI}, "R6 reset clock counts");
        rd_chk(2'd3, 32'h0, "R10 reset status");

        wr(2'd0, 32'hFEFF_FFFF);
        rd_chk(2'd0, 32'h00FF_FF7F, "R1 fields stored, reserved bits zero");
        repeat (20) @(negedge clk);
        rd_chk(2'd0, 32'h00FF_FF7F, "R1 no launch without flag");

        wr(2'd1, 32'hAABB_0305);
        rd_chk(2'd1, 32'h0000_0305, "R6 counts stored, upper bits zero");
        wr(2'd2, 32'h0000_000F);
        rd_chk(2'd2, 32'h0000_0007, "R7 high-speed enable reads 0");

        // Transfer with all bytes acknowledged, minimum counts.
        launch(7'h5A, 8'h3C, 8'hA5, 0, 0, 3);
        repeat (40) @(negedge clk);
        rd_chk(2'd0, 32'h01A5_3C5A, "R2 flag reads 1 while busy");
        wr(2'd0, 32'h0100_1111);
        rd_chk(2'd0, 32'h01A5_3C5A, "R8 write during transfer ignored");
        wait_idle();
        rd_chk(2'd0, 32'h00A5_3C5A, "R2 flag cleared after stop");
        rd_chk(2'd3, 32'h0, "R3 acknowledged write leaves no error");
        repeat (30) @(negedge clk);

        // Register index not acknowledged; clearing write collides with the set.
        launch(7'h11, 8'h80, 8'h01, 3, 5, 1);
        while (!(expq.size() == 0 && lead == 0 && cur_busy)) @(negedge clk);
        reg_we = 1'b1; reg_sel = 2'd3; reg_wdata = 32'h1;
        @(negedge clk);
        reg_we = 1'b0;
        rd_chk(2'd3, 32'h1, "R10 set wins over same-cycle clear");
        rd_chk(2'd0, 32'h0001_8011, "R9 flag cleared after early stop");
        wr(2'd3, 32'h0);
        rd_chk(2'd3, 32'h1, "R10 writing 0 keeps error");
        wr(2'd3, 32'h1);
        rd_chk(2'd3, 32'h0, "R10 writing 1 clears error");

        // Address not acknowledged.
        launch(7'h7F, 8'h00, 8'hFF, 1, 2, 0);
        wait_idle();
        rd_chk(2'd3, 32'h1, "R9 address byte not acknowledged");
        rd_chk(2'd0, 32'h00FF_007F, "R9 flag cleared");
        wr(2'd3, 32'h1);

        // Data byte not acknowledged.
        launch(7'h22, 8'h44, 8'h66, 2, 1, 2);
        wait_idle();
        rd_chk(2'd3, 32'h1, "R9 data byte not acknowledged");
        repeat (10) @(negedge clk);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule